// File: doc/BRIEF.md
# Device-End Byte Link Controller

This block sits on the peripheral side of a four-register link to a host processor. The host writes 3-bit command codes into a command register and reports its own progress in a 2-bit host status register. Both arrive from another clock domain. The block owns the opposite pair: a 2-bit device status register and a data register. Each register has exactly one writer, and the block never drives the host's two.

Once started, the block moves one byte per exchange from a local byte source (valid/ready) to the host:

1. The host raises its status to "waiting".
2. The block announces "fetching" and pulls a byte from the source.
3. It places the byte on the data output, and only afterwards announces "byte available".
4. It holds both until the host reports the byte as taken, then drops back to "ready".

Besides starting transfers, the command set can stop or suspend them, request a rewind from the mechanism, raise a timed alert, and ask for the current status.

Top module: `dev_port_link`

## Requirements
- R1: After reset, dev_stat_o is 00, data_o is 0, and src_ready_o, alert_o and rewind_req_o are all low.
- R2: A command code is acted on once, and only after its synchronized value has been nonzero and unchanged on two consecutive clock cycles. A value held for one clock period is dropped. The same code is accepted again only after cmd_i has taken another value. The command codes are 001 start, 010 halt, 011 rewind, 100 alert, 101 query and 110 pause.
- R3: The device status codes are 00 ready, 01 fetching and 10 byte available, and 11 never appears. Suppose the block is started, not paused and showing 00, and the host status is 01 (waiting). The block then moves to 01, raises src_ready_o, and captures src_data_i on the first cycle in which src_valid_i and src_ready_o are both high.
- R4: data_o changes only while dev_stat_o is 01. It carries the captured byte at least one cycle before dev_stat_o becomes 10.
- R5: While dev_stat_o is 10, both dev_stat_o and data_o hold until the host status reads 10 (taken). dev_stat_o then returns to 00 and waits for the host's next 01.
- R6: Before any start command, or after a halt, a host status of 01 starts no fetch: dev_stat_o stays 00 and src_ready_o stays low.
- R7: Pause stops any new exchange from beginning. A later start command resumes delivery.
- R8: Halt returns dev_stat_o to 00 and drops src_ready_o from any state, including fetching and byte available, and clears the started condition.
- R9: Alert holds alert_o high for exactly ALERT_CYCLES cycles, 16 by default. It does not change dev_stat_o.
- R10: Rewind, when accepted in state 00, raises rewind_req_o and shows dev_stat_o 01 until rewind_done_i is seen. Both then return to low and 00. Rewind is ignored in any other state.
- R11: Query leaves the exchange state unchanged, and dev_stat_o continues to show the current state.
- R12: The codes 000 and 111 are ignored. During a pending byte, dev_stat_o and data_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_stat_i | input | 2 | Host status register, asynchronous to clk |
| cmd_i | input | 3 | Command register written by the host, asynchronous to clk |
| dev_stat_o | output | 2 | Device status register |
| data_o | output | DATA_W | Data register read by the host |
| src_valid_i | input | 1 | Byte source has a byte |
| src_data_i | input | DATA_W | Byte from the source |
| src_ready_o | output | 1 | Block takes a byte this cycle if valid |
| alert_o | output | 1 | Timed alert indicator |
| rewind_req_o | output | 1 | Rewind request to the mechanism |
| rewind_done_i | input | 1 | Mechanism reports rewind finished |

## Verification
The bench uses the default configuration:

- DATA_W = 8, so a sweep of 256 exchanges with an odd-stride byte pattern puts every data value on the data register once.
- SYNC_STAGES = 2.
- ALERT_CYCLES = 16, short enough that the whole alert window is counted cycle by cycle.

Across the sweep, the source gap and the host's acknowledge delay are varied. This covers captures back-to-back and delayed, and long holds in the byte-available state. The small code space lets every command be issued from each of the idle, fetching and byte-available states.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
   typedef enum logic [2:0] {
      CMD_NONE   = 3'b000,
      CMD_START  = 3'b001,
      CMD_HALT   = 3'b010,
      CMD_REWIND = 3'b011,
      CMD_ALERT  = 3'b100,
      CMD_QUERY  = 3'b101,
      CMD_PAUSE  = 3'b110,
      CMD_BAD    = 3'b111
   } cmd_e;

   localparam logic [1:0] DS_READY = 2'b00;
   localparam logic [1:0] DS_BUSY  = 2'b01;
   localparam logic [1:0] DS_FULL  = 2'b10;

   localparam logic [1:0] HS_WAIT  = 2'b01;
   localparam logic [1:0] HS_TAKEN = 2'b10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LOAD,
      ST_SHOW,
      ST_REWIND
   } link_st_e;

   function automatic logic [1:0] stat_of(link_st_e s);
      case (s)
         ST_IDLE: stat_of = DS_READY;
         ST_SHOW: stat_of = DS_FULL;
         default: stat_of = DS_BUSY;
      endcase
   endfunction
endpackage

// File: rtl/dpl_sync.sv
module dpl_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dpl_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("dpl_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_i;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dpl_cmd_filter.sv
module dpl_cmd_filter #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cmd_s_i,
   output logic         acc_o,
   output logic [W-1:0] code_o
);
   logic [W-1:0] prev_q;
   logic         taken_q;

   assign acc_o  = (cmd_s_i != '0) && (cmd_s_i == prev_q) && !taken_q;
   assign code_o = cmd_s_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         taken_q <= 1'b0;
      end else begin
         prev_q  <= cmd_s_i;
         taken_q <= (cmd_s_i != prev_q) ? 1'b0 : (taken_q | acc_o);
      end
   end

   // R2: an accepted command fires for one cycle only
   p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |=> !acc_o);
endmodule

// File: rtl/dpl_alert_timer.sv
module dpl_alert_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic alert_o
);
   localparam int CW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("dpl_alert_timer: CYCLES must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (fire_i)       cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign alert_o = (cnt_q != '0);

   // R9: window counts down one per cycle when not retriggered
   p_alert_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !fire_i) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/dev_port_link.sv
module dev_port_link
   import dpl_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int ALERT_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_stat_i,
   input  logic [2:0]        cmd_i,
   output logic [1:0]        dev_stat_o,
   output logic [DATA_W-1:0] data_o,
   input  logic              src_valid_i,
   input  logic [DATA_W-1:0] src_data_i,
   output logic              src_ready_o,
   output logic              alert_o,
   output logic              rewind_req_o,
   input  logic              rewind_done_i
);
   localparam int CMD_W = 3;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("dev_port_link: DATA_W must be positive");
      end
   endgenerate

   logic [1:0]       hs_s;
   logic [CMD_W-1:0] cmd_s;
   logic             acc;
   logic [CMD_W-1:0] code;

   dpl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_hs_sync (
      .clk(clk), .rst_n(rst_n), .d_i(host_stat_i), .q_o(hs_s));

   dpl_sync #(.W(CMD_W), .STAGES(SYNC_STAGES)) u_cmd_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cmd_i), .q_o(cmd_s));

   dpl_cmd_filter #(.W(CMD_W)) u_filter (
      .clk(clk), .rst_n(rst_n), .cmd_s_i(cmd_s), .acc_o(acc), .code_o(code));

   logic do_start, do_halt, do_rewind, do_alert, do_pause;
   assign do_start  = acc && (code == CMD_START);
   assign do_halt   = acc && (code == CMD_HALT);
   assign do_rewind = acc && (code == CMD_REWIND);
   assign do_alert  = acc && (code == CMD_ALERT);
   assign do_pause  = acc && (code == CMD_PAUSE);

   dpl_alert_timer #(.CYCLES(ALERT_CYCLES)) u_alert (
      .clk(clk), .rst_n(rst_n), .fire_i(do_alert), .alert_o(alert_o));

   link_st_e          st_q, st_n;
   logic              run_q, pause_q;
   logic [1:0]        stat_q;
   logic [DATA_W-1:0] data_q;
   logic              take;

   assign src_ready_o  = (st_q == ST_FETCH) && !do_halt;
   assign take         = src_ready_o && src_valid_i;
   assign rewind_req_o = (st_q == ST_REWIND);
   assign dev_stat_o   = stat_q;
   assign data_o       = data_q;

   always_comb begin
      st_n = st_q;
      if (do_halt) begin
         st_n = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE:
               if (do_rewind)
                  st_n = ST_REWIND;
               else if (run_q && !pause_q && hs_s == HS_WAIT)
                  st_n = ST_FETCH;
            ST_FETCH:  if (take) st_n = ST_LOAD;
            ST_LOAD:   st_n = ST_SHOW;
            ST_SHOW:   if (hs_s == HS_TAKEN) st_n = ST_IDLE;
            ST_REWIND: if (rewind_done_i) st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         stat_q  <= DS_READY;
         run_q   <= 1'b0;
         pause_q <= 1'b0;
         data_q  <= '0;
      end else begin
         st_q   <= st_n;
         stat_q <= stat_of(st_n);
         if (take) data_q <= src_data_i;
         if (do_halt) begin
            run_q   <= 1'b0;
            pause_q <= 1'b0;
         end else if (do_start) begin
            run_q   <= 1'b1;
            pause_q <= 1'b0;
         end else if (do_pause) begin
            pause_q <= 1'b1;
         end
      end
   end

   // R3: status code 11 is never shown
   p_stat_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dev_stat_o != 2'b11);

   // R3: source is only offered a handshake while fetching
   p_ready_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready_o |-> (dev_stat_o == DS_BUSY));

   // R4: data register only moves while status shows fetching
   p_data_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_o) |-> ($past(dev_stat_o) == DS_BUSY));

   // R4: byte already settled when "available" first appears
   p_data_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_stat_o == DS_FULL && $past(dev_stat_o) != DS_FULL) |-> $stable(data_o));

   // R5: available byte is held until the host reports it taken
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SHOW && hs_s != HS_TAKEN && !do_halt)
      |=> (dev_stat_o == DS_FULL && $stable(data_o)));

   // R10: rewind request is always shown as busy
   p_rewind_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rewind_req_o |-> (dev_stat_o == DS_BUSY));

   // R8: halt always lands in the ready state
   p_halt_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      do_halt |=> (dev_stat_o == DS_READY && !src_ready_o));
endmodule

// File: tb/dev_port_link_tb_top.sv
module dev_port_link_tb_top;
   localparam int DW  = 8;
   localparam int ALC = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    host_stat = 2'b00;
   logic [2:0]    cmd = 3'b000;
   logic [1:0]    dev_stat;
   logic [DW-1:0] data;
   logic          src_valid;
   logic [DW-1:0] src_data;
   logic          src_ready;
   logic          alert;
   logic          rw_req;
   logic          rw_done = 1'b0;

   always #10 clk = ~clk;

   dev_port_link #(.DATA_W(DW), .SYNC_STAGES(2), .ALERT_CYCLES(ALC)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_stat_i(host_stat), .cmd_i(cmd),
      .dev_stat_o(dev_stat), .data_o(data), .src_valid_i(src_valid),
      .src_data_i(src_data), .src_ready_o(src_ready), .alert_o(alert),
      .rewind_req_o(rw_req), .rewind_done_i(rw_done));

   int checks = 0;
   int fails  = 0;
   int exp_idx = 0;

   function automatic logic [DW-1:0] pat(int n);
      return DW'(n * 37 + 5);
   endfunction

   // byte source model
   int  src_idx = 0;
   int  gap_cnt = 0;
   int  src_gap = 0;
   bit  src_en = 1'b1;
   assign src_valid = src_en && (gap_cnt == 0);
   assign src_data  = pat(src_idx);
   always @(posedge clk) begin
      if (src_valid && src_ready) begin
         src_idx <= src_idx + 1;
         gap_cnt <= src_gap;
      end else if (gap_cnt != 0) begin
         gap_cnt <= gap_cnt - 1;
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: alert length and data-before-status ordering
   int            alert_total = 0;
   logic [1:0]    prev_stat = 2'b00;
   logic [DW-1:0] prev_data = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (alert) alert_total++;
         check(dev_stat != 2'b11, "R3 legal status", int'(dev_stat), 0);
         if (dev_stat == 2'b10 && prev_stat != 2'b10)
            check(data == prev_data, "R4 data before available",
                  int'(prev_data), int'(data));
         if (data != prev_data)
            check(prev_stat == 2'b01, "R4 data moves only while fetching",
                  int'(prev_stat), 1);
      end
      prev_stat <= dev_stat;
      prev_data <= data;
   end

   task automatic wait_stat(logic [1:0] v, int max, output bit ok);
      ok = 1'b0;
      for (int n = 0; n < max; n++) begin
         if (dev_stat == v) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic send_cmd(logic [2:0] c, int hold);
      @(negedge clk) cmd = c;
      repeat (hold) @(negedge clk);
      cmd = 3'b000;
      repeat (6) @(negedge clk);
   endtask

   task automatic present_byte(string req);
      bit ok;
      @(negedge clk) host_stat = 2'b01;
      wait_stat(2'b10, 200, ok);
      check(ok, req, int'(dev_stat), 2);
      check(data == pat(exp_idx), req, int'(data), int'(pat(exp_idx)));
   endtask

   task automatic ack_byte(string req);
      bit ok;
      host_stat = 2'b10;
      wait_stat(2'b00, 50, ok);
      check(ok, req, int'(dev_stat), 0);
      host_stat = 2'b00;
      exp_idx++;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      summary();
      $finish;
   end

   initial begin
      int base;
      bit ok;
      logic [DW-1:0] held;
      repeat (4) @(negedge clk);
      // R1 reset values
      check(dev_stat == 2'b00, "R1 status", int'(dev_stat), 0);
      check(data == '0, "R1 data", int'(data), 0);
      check(!src_ready && !alert && !rw_req, "R1 outputs",
            int'({src_ready, alert, rw_req}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R6 no start yet
      host_stat = 2'b01;
      repeat (20) @(negedge clk);
      check(dev_stat == 2'b00 && !src_ready, "R6 no fetch before start",
            int'(dev_stat), 0);
      host_stat = 2'b00;

      // R2 one-cycle glitch on command dropped
      base = alert_total;
      send_cmd(3'b100, 1);
      repeat (30) @(negedge clk);
      check(alert_total == base, "R2 glitch ignored", alert_total - base, 0);

      // R2 / R9 long hold gives one window of ALC cycles
      base = alert_total;
      send_cmd(3'b100, 40);
      repeat (30) @(negedge clk);
      check(alert_total - base == ALC, "R9 R2 alert length", alert_total - base, ALC);
      check(dev_stat == 2'b00, "R9 status untouched", int'(dev_stat), 0);

      // R3 R4 R5 sweep over all byte values
      send_cmd(3'b001, 4);
      for (int i = 0; i < 256; i++) begin
         src_gap = i % 4;
         present_byte("R3 byte delivered");
         repeat (i % 3) @(negedge clk);
         check(dev_stat == 2'b10 && data == pat(exp_idx), "R5 hold",
               int'(data), int'(pat(exp_idx)));
         ack_byte("R5 back to ready");
      end
      src_gap = 0;

      // R7 pause and resume
      send_cmd(3'b110, 4);
      host_stat = 2'b01;
      repeat (20) @(negedge clk);
      check(dev_stat == 2'b00 && !src_ready, "R7 paused", int'(dev_stat), 0);
      send_cmd(3'b001, 4);
      present_byte("R7 resumed");
      ack_byte("R7 resumed ack");

      // R8 halt while fetching
      src_en = 1'b0;
      @(negedge clk) host_stat = 2'b01;
      wait_stat(2'b01, 50, ok);
      check(ok && src_ready, "R8 in fetch", int'(dev_stat), 1);
      send_cmd(3'b010, 4);
      check(dev_stat == 2'b00 && !src_ready, "R8 halt from fetch", int'(dev_stat), 0);
      src_en = 1'b1;
      repeat (20) @(negedge clk);
      check(dev_stat == 2'b00, "R6 R8 halted stays idle", int'(dev_stat), 0);
      host_stat = 2'b00;
      send_cmd(3'b001, 4);
      present_byte("R8 restart");
      ack_byte("R8 restart ack");

      // R8 halt while byte available
      present_byte("R8 reach available");
      send_cmd(3'b010, 4);
      check(dev_stat == 2'b00, "R8 halt from available", int'(dev_stat), 0);
      host_stat = 2'b00;
      exp_idx++;
      repeat (4) @(negedge clk);

      // R10 rewind from idle
      send_cmd(3'b011, 4);
      repeat (20) @(negedge clk);
      check(rw_req && dev_stat == 2'b01, "R10 rewinding", int'(dev_stat), 1);
      @(negedge clk) rw_done = 1'b1;
      @(negedge clk) rw_done = 1'b0;
      repeat (3) @(negedge clk);
      check(!rw_req && dev_stat == 2'b00, "R10 rewind done", int'(dev_stat), 0);

      // R10 R11 R12 commands during a pending byte
      send_cmd(3'b001, 4);
      present_byte("R11 reach available");
      held = data;
      send_cmd(3'b011, 4);
      check(dev_stat == 2'b10 && !rw_req && data == held, "R10 rewind ignored",
            int'(dev_stat), 2);
      send_cmd(3'b101, 4);
      check(dev_stat == 2'b10 && data == held, "R11 query no change",
            int'(data), int'(held));
      send_cmd(3'b111, 4);
      check(dev_stat == 2'b10 && data == held, "R12 code 111 ignored",
            int'(data), int'(held));
      ack_byte("R12 ack after ignored");

      summary();
      $finish;
   end
endmodule